// File: doc/BRIEF.md
# Gamepad Port Polling Master

This block is the host side of a single gamepad port on a shared, open-drain serial bus. When `start_i` is pulsed it drives the active-low attention line low and waits a settle gap. It then runs a byte exchange: for each byte it produces eight serial clock periods, sends a command bit on every falling edge and captures a reply bit on every rising edge, least significant bit first. The serial clock comes from a counter divider of the system clock.

Between bytes it waits for the device to pulse its acknowledge line low. If no pulse arrives within a timeout, the packet is abandoned and the port is reported empty. The reply to the second byte is the device identity. Its low nibble sets how many button and axis bytes follow a fixed header byte, and so it sets the length of the rest of the packet. When the packet ends, attention is released and a one-cycle `done_o` pulse is raised together with exactly one of three status flags. The identity byte and the captured data bytes stay on the outputs until the next start.

Top module: `pad_poll_master`

## Requirements
- R1: After a start, `att_no` goes low while `sclk_o` is still high. It stays low through the whole packet and is high in the cycle `done_o` pulses. `done_o` is a single-cycle pulse, issued once per packet.
- R2: `sclk_o` is high whenever `att_no` is high and between bytes. While a byte shifts, each low phase of `sclk_o` lasts exactly `HALF_DIV` system clocks.
- R3: Bits are exchanged least significant bit first. `cmd_o` changes only when `sclk_o` falls or while attention is high, and it holds steady while `sclk_o` is high. Reply bits on `sdi_i` are captured on the rising edge of `sclk_o`.
- R4: The command byte sequence is 0x01, then 0x42, then 0xFF for every later byte.
- R5: After each byte that is not the last, the block waits for `ack_ni` low. If none is seen within `ACK_TMO` system clocks, the packet ends with `nodev_o`=1 and `valid_o`=0, and the port counts as empty.
- R6: The reply captured during byte 2 is presented on `pad_id_o`. Example identities: 0x41 digital, 0x73 and 0x53 analog, 0x23 twist-type.
- R7: If the reply captured during byte 3 is not 0x5A, the packet ends right after byte 3 with `err_o`=1 and `valid_o`=0.
- R8: The number of data bytes is min(2 × `pad_id_o`[3:0], `MAX_DATA`), and the packet is 3 bytes plus that count. Data byte i is placed at `pad_data_o`[8i+7:8i]. Byte slots that are not filled read 0x00.
- R9: No acknowledge is awaited after the last byte. A packet whose device never acknowledges its final byte still completes with `valid_o`=1.
- R10: `start_i` is ignored while a packet is in progress. It produces no second packet and no extra `done_o`.
- R11: Out of reset, `att_no`, `sclk_o` and `cmd_o` are high, and `done_o`, `valid_o`, `err_o`, `nodev_o`, `pad_id_o` and `pad_data_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one poll packet |
| sdi_i | input | 1 | Reply data from the device (pulled up) |
| ack_ni | input | 1 | Device acknowledge, active low (pulled up) |
| att_no | output | 1 | Attention / select, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| cmd_o | output | 1 | Command data to the device |
| done_o | output | 1 | One-cycle end-of-packet pulse |
| valid_o | output | 1 | Packet completed correctly |
| err_o | output | 1 | Header byte mismatch |
| nodev_o | output | 1 | Acknowledge timeout, port empty |
| pad_id_o | output | 8 | Identity byte |
| pad_data_o | output | 8*MAX_DATA | Captured data bytes, byte i at [8i+7:8i] |

## Verification
The assertions assume that the device side only drives `sdi_i` and `ack_ni` as open-drain lines that change at the device's own pace. They also assume `HALF_DIV` is at least 3, so a reply bit set at a falling edge has passed the two-flop synchroniser before the next rising edge. The stimulus uses a behavioural device model that changes its data only on falling `sclk_o` and holds each acknowledge pulse shorter than the inter-byte gap. As a result, a pulse from one byte can never satisfy the wait for the next. `start_i` is pulsed both while idle and in the middle of a packet.

// File: rtl/ppm_pkg.sv
package ppm_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_SETUP, ST_SHIFT, ST_ACKW, ST_GAP} ppm_st_e;
  localparam logic [7:0] CMD_START = 8'h01;
  localparam logic [7:0] CMD_POLL  = 8'h42;
  localparam logic [7:0] CMD_IDLE  = 8'hFF;
  localparam logic [7:0] HDR_OK    = 8'h5A;
endpackage

// File: rtl/ppm_sync.sv
module ppm_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    // pulled-up lines reset to their idle level
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/ppm_shifter.sv
module ppm_shifter #(
  parameter int HALF = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic       idle_i,
  input  logic [7:0] tx_i,
  input  logic       sdi_i,
  output logic       sclk_o,
  output logic       cmd_o,
  output logic [7:0] rx_o,
  output logic       done_o
);
  localparam int CW = $clog2(HALF + 1);

  logic [CW-1:0] cnt_q;
  logic [2:0]    idx_q;
  logic          hi_q, busy_q;
  logic [7:0]    tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      idx_q  <= '0;
      hi_q   <= 1'b0;
      busy_q <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      sclk_o <= 1'b1;
      cmd_o  <= 1'b1;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        busy_q <= 1'b1;
        hi_q   <= 1'b0;
        idx_q  <= '0;
        cnt_q  <= '0;
        tx_q   <= tx_i;
        sclk_o <= 1'b0;
        cmd_o  <= tx_i[0];
      end else if (busy_q) begin
        if (cnt_q == CW'(HALF - 1)) begin
          cnt_q <= '0;
          if (!hi_q) begin
            sclk_o <= 1'b1;
            hi_q   <= 1'b1;
            rx_q   <= {sdi_i, rx_q[7:1]};  // LSB first
          end else if (idx_q == 3'd7) begin
            busy_q <= 1'b0;
            done_o <= 1'b1;
          end else begin
            idx_q  <= idx_q + 3'd1;
            hi_q   <= 1'b0;
            sclk_o <= 1'b0;
            cmd_o  <= tx_q[idx_q + 3'd1];
          end
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end else if (idle_i) begin
        cmd_o <= 1'b1;
      end
    end
  end

  assign rx_o = rx_q;
endmodule

// File: rtl/pad_poll_master.sv
module pad_poll_master
  import ppm_pkg::*;
#(
  parameter int HALF_DIV = 100,
  parameter int GAP_CYC  = 2000,
  parameter int ACK_TMO  = 12000,
  parameter int MAX_DATA = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  sdi_i,
  input  logic                  ack_ni,
  output logic                  att_no,
  output logic                  sclk_o,
  output logic                  cmd_o,
  output logic                  done_o,
  output logic                  valid_o,
  output logic                  err_o,
  output logic                  nodev_o,
  output logic [7:0]            pad_id_o,
  output logic [8*MAX_DATA-1:0] pad_data_o
);
  localparam int TMAX = (GAP_CYC > ACK_TMO) ? GAP_CYC : ACK_TMO;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int KW   = $clog2(MAX_DATA + 4);

  ppm_st_e       st_q;
  logic [TW-1:0] tmr_q;
  logic [KW-1:0] k_q, total_q, total_nx;
  logic          sdi_s, ack_s, go, byte_done;
  logic [7:0]    tx, rx;
  logic [4:0]    n2;
  logic [7:0]    data_q [MAX_DATA];

  ppm_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ack_ni, sdi_i}),
    .q_o   ({ack_s, sdi_s})
  );

  assign tx = (k_q == KW'(0)) ? CMD_START : (k_q == KW'(1)) ? CMD_POLL : CMD_IDLE;
  assign go = ((st_q == ST_SETUP) || (st_q == ST_GAP)) && (tmr_q == TW'(GAP_CYC - 1));

  ppm_shifter #(.HALF(HALF_DIV)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (go),
    .idle_i(att_no),
    .tx_i  (tx),
    .sdi_i (sdi_s),
    .sclk_o(sclk_o),
    .cmd_o (cmd_o),
    .rx_o  (rx),
    .done_o(byte_done)
  );

  // packet length from identity nibble
  assign n2       = {rx[3:0], 1'b0};
  assign total_nx = (int'(n2) > MAX_DATA) ? KW'(3 + MAX_DATA) : KW'(n2) + KW'(3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      tmr_q    <= '0;
      k_q      <= '0;
      total_q  <= KW'(3);
      att_no   <= 1'b1;
      done_o   <= 1'b0;
      valid_o  <= 1'b0;
      err_o    <= 1'b0;
      nodev_o  <= 1'b0;
      pad_id_o <= '0;
      for (int i = 0; i < MAX_DATA; i++) data_q[i] <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          att_no   <= 1'b0;
          tmr_q    <= '0;
          k_q      <= '0;
          valid_o  <= 1'b0;
          err_o    <= 1'b0;
          nodev_o  <= 1'b0;
          pad_id_o <= '0;
          for (int i = 0; i < MAX_DATA; i++) data_q[i] <= '0;
          st_q     <= ST_SETUP;
        end
        ST_SETUP, ST_GAP: begin
          if (go) begin
            tmr_q <= '0;
            st_q  <= ST_SHIFT;
          end else begin
            tmr_q <= tmr_q + TW'(1);
          end
        end
        ST_SHIFT: if (byte_done) begin
          k_q <= k_q + KW'(1);
          if (k_q == KW'(1)) begin
            pad_id_o <= rx;
            total_q  <= total_nx;
          end
          for (int i = 0; i < MAX_DATA; i++)
            if (int'(k_q) == i + 3) data_q[i] <= rx;
          if (k_q == KW'(2) && rx != HDR_OK) begin
            att_no <= 1'b1;
            done_o <= 1'b1;
            err_o  <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (k_q != KW'(1) && (k_q + KW'(1)) == total_q) begin
            att_no  <= 1'b1;
            done_o  <= 1'b1;
            valid_o <= 1'b1;
            st_q    <= ST_IDLE;
          end else begin
            tmr_q <= '0;
            st_q  <= ST_ACKW;
          end
        end
        ST_ACKW: begin
          if (!ack_s) begin
            tmr_q <= '0;
            st_q  <= ST_GAP;
          end else if (tmr_q == TW'(ACK_TMO - 1)) begin
            att_no  <= 1'b1;
            done_o  <= 1'b1;
            nodev_o <= 1'b1;
            st_q    <= ST_IDLE;
          end else begin
            tmr_q <= tmr_q + TW'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < MAX_DATA; g++) begin : g_out
    assign pad_data_o[8*g +: 8] = data_q[g];
  end
endmodule

// File: rtl/ppm_chk.sv
module ppm_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic att_no,
  input logic sclk_o,
  input logic cmd_o,
  input logic done_o,
  input logic valid_o,
  input logic err_o,
  input logic nodev_o
);
  a_r2_sclk_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    att_no |-> sclk_o);
  a_r2_fall_only_selected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> !att_no);
  a_r1_att_fall_clock_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(att_no) |-> sclk_o);
  a_r1_done_att_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> att_no);
  a_r1_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r3_cmd_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!att_no && sclk_o && $past(sclk_o)) |-> $stable(cmd_o));
  a_r5_status_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($countones({valid_o, err_o, nodev_o}) == 1));
endmodule

bind pad_poll_master ppm_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .att_no (att_no),
  .sclk_o (sclk_o),
  .cmd_o  (cmd_o),
  .done_o (done_o),
  .valid_o(valid_o),
  .err_o  (err_o),
  .nodev_o(nodev_o)
);

// File: tb/pad_poll_master_tb_top.sv
`timescale 1ns/1ps
module pad_poll_master_tb_top;
  localparam int HALF = 4, GAP = 6, TMO = 40, MAXD = 6;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sdi = 1'b1, ack_n = 1'b1;
  logic att_n, sclk, cmd, done, valid, err, nodev;
  logic [7:0] pid;
  logic [8*MAXD-1:0] pdata;

  always #2.5 clk = ~clk;

  pad_poll_master #(.HALF_DIV(HALF), .GAP_CYC(GAP), .ACK_TMO(TMO), .MAX_DATA(MAXD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sdi_i(sdi), .ack_ni(ack_n),
    .att_no(att_n), .sclk_o(sclk), .cmd_o(cmd), .done_o(done), .valid_o(valid),
    .err_o(err), .nodev_o(nodev), .pad_id_o(pid), .pad_data_o(pdata)
  );

  int vectors = 0, miscompares = 0;
  int mon_vec = 0, mon_fail = 0, wd_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural device model
  logic [7:0] pad_bytes[$];
  logic [7:0] cmd_q[$];
  bit pad_present = 1'b0;
  int stop_ack = -1;
  int bitn = 0, byten = 0, ack_tok = 0, ack_seen = 0, ack_cnt = 0;
  logic [7:0] rxc = 8'h00;

  always @(posedge sclk or posedge att_n) begin
    if (att_n) begin
      bitn = 0;
      byten = 0;
    end else begin
      rxc[bitn] = cmd;
      bitn++;
      if (bitn == 8) begin
        cmd_q.push_back(rxc);
        if (pad_present && byten != stop_ack && byten < pad_bytes.size() - 1) ack_tok++;
        byten++;
        bitn = 0;
      end
    end
  end

  always @(negedge sclk or posedge att_n) begin
    if (att_n) sdi = 1'b1;
    else if (pad_present) sdi = (byten < pad_bytes.size()) ? pad_bytes[byten][bitn] : 1'b1;
  end

  always @(posedge clk) begin
    if (ack_tok != ack_seen) begin
      ack_seen = ack_tok;
      ack_cnt = 1;
    end else if (ack_cnt > 0) begin
      ack_cnt = (ack_cnt == 8) ? 0 : ack_cnt + 1;
    end
    ack_n <= !(ack_cnt >= 4 && ack_cnt < 8);
  end

  // per-clock reference: idle clock level, low-phase width, done count
  int lowrun = 0, ndone = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      mon_vec++;
      if (att_n && !sclk) begin
        mon_fail++;
        $display("FAIL R2 idle clock actual=%0d expected=1", sclk);
      end
      if (!sclk) lowrun++;
      else if (lowrun > 0) begin
        mon_vec++;
        if (lowrun != HALF) begin
          mon_fail++;
          $display("FAIL R2 low phase actual=%0d expected=%0d", lowrun, HALF);
        end
        lowrun = 0;
      end
      if (done) ndone++;
    end
  end

  // kind: 0 valid, 1 header error, 2 no device
  task automatic run_pkt(input logic [7:0] id, input logic [7:0] hdr, input int npad,
                         input bit present, input int stop, input int kind,
                         input int ncmd, input bit poke, input string tag);
    int base, d0, nd;
    bit got;
    pad_bytes.delete();
    pad_bytes.push_back(8'hFF);
    pad_bytes.push_back(id);
    pad_bytes.push_back(hdr);
    for (int i = 0; i < npad; i++) pad_bytes.push_back(8'((i * 37 + 5) ^ id));
    pad_present = present;
    stop_ack = stop;
    base = cmd_q.size();
    d0 = ndone;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (poke) begin
      repeat (60) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    got = 1'b0;
    for (int c = 0; c < 5000; c++) begin
      @(negedge clk);
      if (done) begin got = 1'b1; break; end
    end
    chk(got, {tag, " R1 done seen"}, 64'(got), 1);
    if (got) begin
      chk(att_n == 1'b1, {tag, " R1 att high at done"}, 64'(att_n), 1);
      chk({valid, err, nodev} == 3'(1 << (2 - kind)), {tag, " R5/R7 status"},
          64'({valid, err, nodev}), 64'(1 << (2 - kind)));
      if (kind != 2) chk(pid == id, {tag, " R6 identity"}, 64'(pid), 64'(id));
      if (kind == 0) begin
        nd = 2 * int'(id[3:0]);
        if (nd > MAXD) nd = MAXD;
        for (int i = 0; i < MAXD; i++) begin
          logic [7:0] e;
          e = (i < nd) ? pad_bytes[3 + i] : 8'h00;
          chk(pdata[8*i +: 8] == e, {tag, " R8 data byte"}, 64'(pdata[8*i +: 8]), 64'(e));
        end
      end
    end
    chk(cmd_q.size() - base == ncmd, {tag, " R4/R8 byte count"}, 64'(cmd_q.size() - base), 64'(ncmd));
    for (int j = 0; j < ncmd && base + j < cmd_q.size(); j++) begin
      logic [7:0] e;
      e = (j == 0) ? 8'h01 : (j == 1) ? 8'h42 : 8'hFF;
      chk(cmd_q[base + j] == e, {tag, " R3/R4 command byte"}, 64'(cmd_q[base + j]), 64'(e));
    end
    repeat (20) @(negedge clk);
    chk(ndone - d0 == 1, {tag, " R10 single done"}, 64'(ndone - d0), 1);
    chk(att_n == 1'b1, {tag, " R10 stays idle"}, 64'(att_n), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(att_n && sclk && cmd, "R11 idle lines", 64'({att_n, sclk, cmd}), 64'h7);
    chk({done, valid, err, nodev} == 4'h0, "R11 flags", 64'({done, valid, err, nodev}), 0);
    chk(pid == 8'h00 && pdata == '0, "R11 data", 64'(pid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_pkt(8'h73, 8'h5A, 6,  1, -1, 0, 9, 0, "analog");
    run_pkt(8'h41, 8'h5A, 2,  1, -1, 0, 5, 0, "digital");
    run_pkt(8'h53, 8'h5A, 6,  1, -1, 0, 9, 0, "analog2");
    run_pkt(8'h23, 8'h5A, 6,  1, -1, 0, 9, 0, "twist");
    run_pkt(8'h45, 8'h5A, 10, 1, -1, 0, 9, 0, "R8 cap");
    run_pkt(8'h40, 8'h5A, 0,  1, -1, 0, 3, 0, "R9 header only");
    run_pkt(8'h41, 8'h5B, 2,  1, -1, 1, 3, 0, "R7 bad header");
    run_pkt(8'h41, 8'h5A, 2,  0, -1, 2, 1, 0, "R5 empty port");
    run_pkt(8'h73, 8'h5A, 6,  1, 4,  2, 5, 0, "R5 late timeout");
    run_pkt(8'h41, 8'h5A, 2,  1, -1, 0, 5, 1, "R10 busy start");
    $display("== %0d vectors applied, %0d miscompares ==",
             vectors + mon_vec, miscompares + mon_fail + wd_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    wd_fail = 1;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==",
             vectors + mon_vec, miscompares + mon_fail + wd_fail);
    $finish;
  end
endmodule